// File: doc/BRIEF.md
# Execution Mode Switch Controller

This controller decides whether a core should run in a wide out-of-order mode or in a many-threaded in-order mode, and it sequences the changeover between the two. It samples the number of active hardware threads each cycle. When the count calls for the mode the core is not in, it runs an ordered changeover. The steps are: wait for the pipeline to empty, have an external transfer engine save the architectural state of the running threads, switch the out-of-order-only units on or off, and have the same engine load the state of the threads that will run next.

The controller carries no register data. It only issues requests to the transfer engine and waits for that engine's completion pulse. Fetch is held off for the whole changeover. A counter records the length of the most recent changeover in cycles. In practice a changeover lasts several hundred cycles, and nearly all of that time is the drain and the two transfers.

Top module: `mode_switch_ctrl`

## Requirements
- R1: The thread count is registered once per cycle. A registered count of at most OOO_LIMIT (default 2) targets out-of-order mode (`mode_ooo`=1), and a larger count targets in-order mode. After reset the mode is out-of-order. A new count applied before clock edge A causes `busy` to rise after edge A+1.
- R2: While idle, a target equal to the current mode starts nothing, and `busy` stays low.
- R3: The first step of a changeover holds until `pipe_empty` is sampled high. `spill_req` is never raised before that.
- R4: `spill_req` is high from the cycle after the empty pipeline is seen until the cycle in which `xfer_done` is sampled. `xfer_done` has no effect outside the save and load steps.
- R5: `unit_en` bit 0 (rename), bit 1 (out-of-order scheduling) and bit 2 (load queue) are all 1 in out-of-order mode and all 0 in in-order mode. They change on the same edge as `mode_ooo`.
- R6: After exactly one reconfigure cycle, `fill_req` is high until `xfer_done` is sampled. `rat_update` is high during the load step only when the new mode is out-of-order.
- R7: `busy` and `fetch_stall` are high from the first drain cycle through the last load cycle, and low otherwise.
- R8: Count changes during a changeover do not alter it. The count held at its end is evaluated in the following idle cycle and can start a new changeover at once.
- R9: `last_cycles` is 0 after reset. When a changeover ends, it takes the number of cycles `busy` was high during that changeover.
- R10: `mode_ooo` changes only on the edge that leaves the reconfigure step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thread_cnt | input | CNT_W (4) | Number of active threads |
| pipe_empty | input | 1 | Pipeline holds no instructions |
| xfer_done | input | 1 | Transfer engine finished the current save or load |
| mode_ooo | output | 1 | 1 = out-of-order mode, 0 = in-order mode |
| busy | output | 1 | Changeover in progress |
| fetch_stall | output | 1 | Hold instruction fetch |
| spill_req | output | 1 | Request a save of architectural state |
| fill_req | output | 1 | Request a load of architectural state |
| rat_update | output | 1 | The load must also rebuild the rename tables |
| unit_en | output | UNIT_N (3) | Enables of the mode-dependent units |
| last_cycles | output | CYC_W (16) | Length of the latest changeover |

## Verification
A corrupt step register shows up in the very next cycle as a request or stall flag that disagrees with the expected step. A mode bit flipped at the wrong moment shows up the same cycle as a wrong `mode_ooo` or a `unit_en` that no longer matches it. A mis-latched thread count shows up two edges later, as a changeover that starts or fails to start. Any miscounted length only becomes visible when the changeover closes, through `last_cycles`.

// File: rtl/msc_pkg.sv
`timescale 1ns/1ps
package msc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_DRAIN  = 3'd1,
      ST_SPILL  = 3'd2,
      ST_RECONF = 3'd3,
      ST_FILL   = 3'd4
   } msc_state_e;
endpackage

// File: rtl/msc_policy.sv
`timescale 1ns/1ps
module msc_policy #(
   parameter int MAX_THREADS = 8,
   parameter int OOO_LIMIT   = 2,
   localparam int CNT_W      = $clog2(MAX_THREADS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] thread_cnt,
   output logic             want_ino
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(OOO_LIMIT);

   logic [CNT_W-1:0] cnt_q;

   // count is sampled every cycle; the sequencer only looks at it while idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= thread_cnt;
   end

   assign want_ino = (cnt_q > LIMIT);
endmodule

// File: rtl/msc_timer.sv
`timescale 1ns/1ps
module msc_timer #(
   parameter int CYC_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             active,
   input  logic             finish,
   output logic [CYC_W-1:0] last_cycles
);
   logic [CYC_W-1:0] run_q;
   logic [CYC_W-1:0] run_nx;

   generate
      if (SATURATE) begin : g_sat
         assign run_nx = (&run_q) ? run_q : run_q + 1'b1;
      end else begin : g_wrap
         assign run_nx = run_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q       <= '0;
         last_cycles <= '0;
      end else begin
         if (start)       run_q <= '0;
         else if (active) run_q <= run_nx;
         if (finish)      last_cycles <= run_nx;
      end
   end

   // a changeover spans at least drain, save, reconfigure and load
   assert_min_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(finish) |-> (last_cycles >= CYC_W'(4)));
endmodule

// File: rtl/msc_seq.sv
`timescale 1ns/1ps
module msc_seq
   import msc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       want_ino,
   input  logic       pipe_empty,
   input  logic       xfer_done,
   output msc_state_e state,
   output logic       mode_ino,
   output logic       start,
   output logic       finish
);
   msc_state_e state_q, state_d;
   logic       mode_q;

   assign start  = (state_q == ST_IDLE) && (want_ino != mode_q);
   assign finish = (state_q == ST_FILL) && xfer_done;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (start)      state_d = ST_DRAIN;
         ST_DRAIN:  if (pipe_empty) state_d = ST_SPILL;
         ST_SPILL:  if (xfer_done)  state_d = ST_RECONF;
         ST_RECONF:                 state_d = ST_FILL;
         ST_FILL:   if (xfer_done)  state_d = ST_IDLE;
         default:                   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_RECONF) mode_q <= ~mode_q;
      end
   end

   assign state    = state_q;
   assign mode_ino = mode_q;

   assert_save_after_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SPILL && $past(state_q) == ST_DRAIN) |-> $past(pipe_empty));

   assert_mode_flip_at_reconf_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != $past(mode_q)) |-> ($past(state_q) == ST_RECONF));

   assert_load_ends_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == ST_FILL && state_q == ST_IDLE) |-> $past(xfer_done));
endmodule

// File: rtl/msc_unit_gate.sv
`timescale 1ns/1ps
module msc_unit_gate #(
   parameter int              UNIT_N        = 3,
   parameter logic [UNIT_N-1:0] OOO_ONLY_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              to_ino,
   output logic [UNIT_N-1:0] unit_en
);
   generate
      for (genvar u = 0; u < UNIT_N; u++) begin : g_unit
         if (OOO_ONLY_MASK[u]) begin : g_gated
            logic en_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)    en_q <= 1'b1;
               else if (load) en_q <= ~to_ino;
            end
            assign unit_en[u] = en_q;
         end else begin : g_always
            assign unit_en[u] = 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/mode_switch_ctrl.sv
`timescale 1ns/1ps
module mode_switch_ctrl
   import msc_pkg::*;
#(
   parameter int                MAX_THREADS   = 8,
   parameter int                OOO_LIMIT     = 2,
   parameter int                UNIT_N        = 3,
   parameter logic [UNIT_N-1:0] OOO_ONLY_MASK = '1,
   parameter int                CYC_W         = 16,
   parameter bit                SATURATE      = 1'b1,
   localparam int               CNT_W         = $clog2(MAX_THREADS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  thread_cnt,
   input  logic              pipe_empty,
   input  logic              xfer_done,
   output logic              mode_ooo,
   output logic              busy,
   output logic              fetch_stall,
   output logic              spill_req,
   output logic              fill_req,
   output logic              rat_update,
   output logic [UNIT_N-1:0] unit_en,
   output logic [CYC_W-1:0]  last_cycles
);
   generate
      if (OOO_LIMIT < 1 || OOO_LIMIT >= MAX_THREADS) begin : g_bad_limit
         $error("OOO_LIMIT must lie in 1..MAX_THREADS-1");
      end
      if (UNIT_N < 1) begin : g_bad_units
         $error("UNIT_N must be at least 1");
      end
      if (CYC_W < 4) begin : g_bad_cyc
         $error("CYC_W must be at least 4");
      end
   endgenerate

   logic       want_ino;
   msc_state_e state;
   logic       mode_ino;
   logic       start;
   logic       finish;

   msc_policy #(.MAX_THREADS(MAX_THREADS), .OOO_LIMIT(OOO_LIMIT)) u_policy (
      .clk(clk), .rst_n(rst_n), .thread_cnt(thread_cnt), .want_ino(want_ino));

   msc_seq u_seq (
      .clk(clk), .rst_n(rst_n), .want_ino(want_ino), .pipe_empty(pipe_empty),
      .xfer_done(xfer_done), .state(state), .mode_ino(mode_ino),
      .start(start), .finish(finish));

   msc_timer #(.CYC_W(CYC_W), .SATURATE(SATURATE)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start), .active(busy),
      .finish(finish), .last_cycles(last_cycles));

   msc_unit_gate #(.UNIT_N(UNIT_N), .OOO_ONLY_MASK(OOO_ONLY_MASK)) u_gate (
      .clk(clk), .rst_n(rst_n), .load(state == ST_RECONF),
      .to_ino(~mode_ino), .unit_en(unit_en));

   assign mode_ooo    = ~mode_ino;
   assign busy        = (state != ST_IDLE);
   assign fetch_stall = busy;
   assign spill_req   = (state == ST_SPILL);
   assign fill_req    = (state == ST_FILL);
   assign rat_update  = fill_req & ~mode_ino;

   // enable registers and mode register are separate flops that must agree
   assert_units_track_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
      unit_en == (mode_ooo ? {UNIT_N{1'b1}} : ~OOO_ONLY_MASK));

   assert_no_request_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (spill_req | fill_req) |-> fetch_stall);
endmodule

// File: tb/mode_switch_ctrl_test.sv
`timescale 1ns/1ps
module mode_switch_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  thread_cnt = '0;
   logic        pipe_empty = 1'b0;
   logic        xfer_done = 1'b0;
   logic        mode_ooo, busy, fetch_stall, spill_req, fill_req, rat_update;
   logic [2:0]  unit_en;
   logic [15:0] last_cycles;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mode_switch_ctrl uut (
      .clk(clk), .rst_n(rst_n), .thread_cnt(thread_cnt), .pipe_empty(pipe_empty),
      .xfer_done(xfer_done), .mode_ooo(mode_ooo), .busy(busy),
      .fetch_stall(fetch_stall), .spill_req(spill_req), .fill_req(fill_req),
      .rat_update(rat_update), .unit_en(unit_en), .last_cycles(last_cycles));

   // behavioural reference: phase 0 idle, 1 drain, 2 save, 3 reconfigure, 4 load
   int m_phase, m_cnt, m_run, m_last;
   bit m_ino;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase = 0; m_cnt = 0; m_run = 0; m_last = 0; m_ino = 1'b0;
      end else begin
         case (m_phase)
            0: if ((m_cnt > 2) != m_ino) begin m_phase = 1; m_run = 0; end
            1: begin m_run++; if (pipe_empty) m_phase = 2; end
            2: begin m_run++; if (xfer_done) m_phase = 3; end
            3: begin m_run++; m_ino = ~m_ino; m_phase = 4; end
            default: begin
               if (xfer_done) begin m_last = m_run + 1; m_phase = 0; end
               else m_run++;
            end
         endcase
         m_cnt = int'(thread_cnt);
      end
   end

   task automatic check(string tag, string what, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic check_all();
      check("R1 R10", "mode_ooo", int'(mode_ooo), int'(!m_ino));
      check("R7 R2 R8", "busy", int'(busy), int'(m_phase != 0));
      check("R7", "fetch_stall", int'(fetch_stall), int'(m_phase != 0));
      check("R3 R4", "spill_req", int'(spill_req), int'(m_phase == 2));
      check("R6", "fill_req", int'(fill_req), int'(m_phase == 4));
      check("R6", "rat_update", int'(rat_update), int'(m_phase == 4 && !m_ino));
      check("R5", "unit_en", int'(unit_en), m_ino ? 0 : 7);
      check("R9", "last_cycles", int'(last_cycles), m_last);
   endtask

   task automatic drive(int c, bit pe, bit xd);
      @(negedge clk);
      check_all();
      thread_cnt = 4'(c);
      pipe_empty = pe;
      xfer_done  = xd;
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         compared++; mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      int c;
      // reset state checks (R1, R9)
      repeat (3) drive(0, 1'b0, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      // R2: count at the threshold 2 keeps out-of-order, done pulses ignored
      for (int i = 0; i < 6; i++) drive((i % 2) + 1, 1'b1, 1'b1);
      // R1 R3 R4: count 3 starts a changeover; drain waits, done ignored while draining
      for (int i = 0; i < 6; i++) drive(3, 1'b0, 1'b1);
      drive(3, 1'b1, 1'b0);
      for (int i = 0; i < 3; i++) drive(3, 1'b0, 1'b0);
      drive(3, 1'b0, 1'b1);
      // R8: count drops during the changeover; R6 load to in-order has no table rebuild
      for (int i = 0; i < 4; i++) drive(1, 1'b0, 1'b0);
      drive(1, 1'b0, 1'b1);
      // R8 R6: the held count triggers a return to out-of-order with table rebuild
      for (int i = 0; i < 3; i++) drive(1, 1'b0, 1'b0);
      drive(1, 1'b1, 1'b0);
      drive(1, 1'b0, 1'b1);
      for (int i = 0; i < 2; i++) drive(1, 1'b0, 1'b0);
      drive(1, 1'b0, 1'b1);
      for (int i = 0; i < 5; i++) drive(2, 1'b0, 1'b0);
      // R9: long changeover to eight threads, about 400 cycles
      for (int i = 0; i < 200; i++) drive(8, 1'b0, 1'b0);
      drive(8, 1'b1, 1'b0);
      for (int i = 0; i < 100; i++) drive(8, 1'b0, 1'b0);
      drive(8, 1'b0, 1'b1);
      for (int i = 0; i < 100; i++) drive(8, 1'b0, 1'b0);
      drive(8, 1'b0, 1'b1);
      for (int i = 0; i < 5; i++) drive(8, 1'b0, 1'b0);
      // mixed traffic across all requirements
      c = 8;
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 30) == 0) c = $urandom_range(0, 8);
         drive(c, $urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0);
      end
      drive(c, 1'b0, 1'b0);
      done = 1'b1;
      report();
   end
endmodule